// File: doc/BRIEF.md
# Serial Dot-Matrix Display Command Decoder

This block sits between a three-wire serial host link and the character memory of an eight-position, 5x7 dot-matrix display. The host frames each byte with an active-low load strobe. While the strobe is low, the block shifts in one data bit on every rising edge of the serial clock, least significant bit first. On the strobe's rising edge the collected byte is decoded. The top three bits choose the operation and the low five bits carry its payload.

A decoded byte does one of four things. It selects a character position, writes one 5-bit row of dots into that character with automatic row advance, updates the brightness/current/prescale control word, or requests a software clear of the character memory. Writes leave the block as a one-cycle memory write port (character, row, five column bits). The clear leaves as a one-cycle strobe. The control word is presented as static fields, together with a power-down flag for the 0% brightness setting.

All three serial inputs are asynchronous to the system clock. They are brought into the clock domain before any edge is detected, so the serial clock must run well below the system clock.

Top module: `disp_ser_cmd`

## Requirements
- R1: Serial inputs pass through a two-stage synchroniser. A bit is captured into the byte register on a rising serial-clock edge seen while load is low, filling from the top so the first bit sent ends in bit 0. The byte is decoded once per rising edge of load, and its effect is visible at the outputs on the third system-clock edge after load goes high.
- R2: A byte with bits 7..5 = 101 sets the current character to bits 2..0 and resets the row pointer to row 0. No memory write occurs.
- R3: A byte with bits 7..5 = 000 pulses `ram_we_o` for exactly one cycle, with `ram_char_o` set to the current character, `ram_row_o` set to the row pointer and `ram_cols_o` set to bits 4..0. The row pointer then advances by one.
- R4: Once row 6 has been written, the row pointer stays at 6, and further data bytes rewrite row 6.
- R5: A character select that arrives part way through a character sends the next data byte to row 0 of the new character. No write reaches the rows of the old character that were not yet written.
- R6: A byte with bits 7..5 = 111 loads the control word. Bits 2..0 set `bright_o` (0 = full, 7 = off), bit 3 sets `full_pk_o` (1 = full peak current, 0 = 12.5%), and bit 4 sets `div16_o` (1 = prescale by 16).
- R7: `pwr_dn_o` is high exactly when `bright_o` is 7. Data writes are still carried out in that state. A later control word with another level clears the flag.
- R8: A byte with bits 7..5 = 110 pulses `ram_clr_o` for one cycle and sets the character and row to 0. The control word is left unchanged.
- R9: Active-low asynchronous reset sets character 0, row 0, the byte register to 0, `bright_o` = 0, `full_pk_o` = 1 and `div16_o` = 0, with no write or clear pulse.
- R10: Bytes with bits 7..5 equal to 001, 010, 011 or 100 cause no write, no clear, and no change to the control word, character or row pointer.
- R11: A load rising edge after fewer than eight serial clocks decodes the byte register as it stands. The bits shifted in occupy the top, and older bits move down.
- R12: Serial clock edges while load is high do not change the byte register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, LSB first |
| ser_ld_n_i | input | 1 | Byte framing strobe, low while shifting |
| ram_we_o | output | 1 | Character memory write strobe |
| ram_char_o | output | 3 | Character position of the write |
| ram_row_o | output | 3 | Row (0 top .. 6 bottom) of the write |
| ram_cols_o | output | 5 | Column dots C0..C4 in bits 4..0 |
| ram_clr_o | output | 1 | Clear-all strobe for the character memory |
| bright_o | output | 3 | Brightness level, 0 full .. 7 off |
| full_pk_o | output | 1 | 1 full peak current, 0 reduced |
| div16_o | output | 1 | 1 multiplex clock prescaled by 16 |
| pwr_dn_o | output | 1 | Display powered down (level 7) |

## Verification
Every decoded result appears on the third rising system-clock edge after load is driven high. That is two synchroniser flops plus the decoder register. The bench drives load at a falling edge, waits exactly three rising edges, and samples 2 ns later, so the write strobe, clear strobe and control fields are all checked in the single cycle in which they first become valid. One cycle later it checks that the strobes have dropped. Row-pointer and character state have no port of their own, so they are checked through the row and character carried by the next write.

// File: rtl/disp_ser_cmd_pkg.sv
package disp_ser_cmd_pkg;

    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OPC_COLS = 3'b000;
    localparam logic [OPC_W-1:0] OPC_SEL  = 3'b101;
    localparam logic [OPC_W-1:0] OPC_CLR  = 3'b110;
    localparam logic [OPC_W-1:0] OPC_CTL  = 3'b111;

    localparam int LVL_W = 3;

    typedef struct packed {
        logic             div16;
        logic             full_pk;
        logic [LVL_W-1:0] level;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    localparam ctl_word_t CTL_RESET = '{div16: 1'b0, full_pk: 1'b1, level: '0};

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int                N_SIG  = 3,
    parameter int                STAGES = 2,
    parameter logic [N_SIG-1:0]  IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_i,
    output logic [N_SIG-1:0] lvl_o,
    output logic [N_SIG-1:0] rise_o
);

    typedef struct packed {
        logic [STAGES-1:0][N_SIG-1:0] chain;
        logic [N_SIG-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{IDLE}};
            st_q.prev  <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.chain[STAGES-1];
    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/dsc_shift.sv
module dsc_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] shreg_d, shreg_q;

    always_comb begin
        shreg_d = shreg_q;
        if (shift_en) begin
            shreg_d = {bit_i, shreg_q[BYTE_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else begin
            shreg_q <= shreg_d;
        end
    end

    assign byte_o = shreg_q;

endmodule

// File: rtl/dsc_decode.sv
module dsc_decode
    import disp_ser_cmd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CHAR_W = 3,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 5,
    parameter int N_ROWS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              we_o,
    output logic [CHAR_W-1:0] char_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  cols_o,
    output logic              clr_o,
    output ctl_word_t         ctl_o
);

    localparam int               OPC_LSB  = BYTE_W - OPC_W;
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(N_ROWS - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
        ctl_word_t         ctl;
        logic              we;
        logic [CHAR_W-1:0] we_char;
        logic [ROW_W-1:0]  we_row;
        logic [COL_W-1:0]  we_cols;
        logic              clr;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic [OPC_W-1:0] opc;
    assign opc = byte_i[BYTE_W-1:OPC_LSB];

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.clr = 1'b0;
        if (frame_i) begin
            case (opc)
                OPC_SEL: begin
                    st_d.addr = byte_i[CHAR_W-1:0];
                    st_d.row  = '0;
                end
                OPC_COLS: begin
                    st_d.we      = 1'b1;
                    st_d.we_char = st_q.addr;
                    st_d.we_row  = st_q.row;
                    st_d.we_cols = byte_i[COL_W-1:0];
                    if (st_q.row != ROW_LAST) begin
                        st_d.row = st_q.row + 1'b1;
                    end
                end
                OPC_CTL: begin
                    st_d.ctl = ctl_word_t'(byte_i[CTL_W-1:0]);
                end
                OPC_CLR: begin
                    st_d.addr = '0;
                    st_d.row  = '0;
                    st_d.clr  = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr    <= '0;
            st_q.row     <= '0;
            st_q.ctl     <= CTL_RESET;
            st_q.we      <= 1'b0;
            st_q.we_char <= '0;
            st_q.we_row  <= '0;
            st_q.we_cols <= '0;
            st_q.clr     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o   = st_q.we;
    assign char_o = st_q.we_char;
    assign row_o  = st_q.we_row;
    assign cols_o = st_q.we_cols;
    assign clr_o  = st_q.clr;
    assign ctl_o  = st_q.ctl;

    // R4: the row pointer never leaves the character
    p_row_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row <= ROW_LAST);

    // R3: a data byte moves the pointer one row down unless at the bottom
    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && opc == OPC_COLS && st_q.row != ROW_LAST)
        |=> (st_q.row == $past(st_q.row) + 1'b1));

    // R2: a select byte lands its character and rewinds the row
    p_sel_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && opc == OPC_SEL)
        |=> (st_q.row == '0 && st_q.addr == $past(byte_i[CHAR_W-1:0])));

    // R8: write and clear strobes never coincide
    p_we_clr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_o && clr_o));

    // R8: a clear leaves the control word alone
    p_clr_keeps_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> $stable(ctl_o));

    // R6: the control word moves only after a decoded frame
    p_ctl_needs_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_i) |-> $stable(ctl_o));

endmodule

// File: rtl/disp_ser_cmd.sv
module disp_ser_cmd
    import disp_ser_cmd_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int CHAR_W      = 3,
    parameter int ROW_W       = 3,
    parameter int COL_W       = 5,
    parameter int N_ROWS      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_ld_n_i,
    output logic              ram_we_o,
    output logic [CHAR_W-1:0] ram_char_o,
    output logic [ROW_W-1:0]  ram_row_o,
    output logic [COL_W-1:0]  ram_cols_o,
    output logic              ram_clr_o,
    output logic [LVL_W-1:0]  bright_o,
    output logic              full_pk_o,
    output logic              div16_o,
    output logic              pwr_dn_o
);

    localparam int               N_SIG   = 3;
    localparam int               IX_CLK  = 0;
    localparam int               IX_DAT  = 1;
    localparam int               IX_LD   = 2;
    localparam logic [N_SIG-1:0] IDLE    = N_SIG'(1) << IX_LD;
    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    logic [N_SIG-1:0]  raw, lvl, rise;
    logic              shift_en;
    logic              frame;
    logic [BYTE_W-1:0] shreg;
    ctl_word_t         ctl;

    assign raw = {ser_ld_n_i, ser_dat_i, ser_clk_i};

    dsc_sync #(
        .N_SIG  (N_SIG),
        .STAGES (SYNC_STAGES),
        .IDLE   (IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .lvl_o   (lvl),
        .rise_o  (rise)
    );

    assign shift_en = rise[IX_CLK] & ~lvl[IX_LD];
    assign frame    = rise[IX_LD];

    dsc_shift #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_i    (lvl[IX_DAT]),
        .byte_o   (shreg)
    );

    dsc_decode #(
        .BYTE_W (BYTE_W),
        .CHAR_W (CHAR_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .N_ROWS (N_ROWS)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame),
        .byte_i  (shreg),
        .we_o    (ram_we_o),
        .char_o  (ram_char_o),
        .row_o   (ram_row_o),
        .cols_o  (ram_cols_o),
        .clr_o   (ram_clr_o),
        .ctl_o   (ctl)
    );

    assign bright_o  = ctl.level;
    assign full_pk_o = ctl.full_pk;
    assign div16_o   = ctl.div16;
    assign pwr_dn_o  = (ctl.level == LVL_OFF);

    // R12: with load high the byte register holds
    p_hold_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[IX_LD] |=> $stable(shreg));

    // R1: one decode per load edge, never on two cycles running
    p_single_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> !frame);

    // R3: a write strobe lasts one cycle
    p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> !ram_we_o);

endmodule

// File: tb/tb_disp_ser_cmd.sv
module tb_disp_ser_cmd;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       sdat = 1'b0;
    logic       sld_n = 1'b1;
    logic       we, clr, pk, dv, pd;
    logic [2:0] ch, rw, lvl;
    logic [4:0] cols;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    disp_ser_cmd dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (sck),
        .ser_dat_i  (sdat),
        .ser_ld_n_i (sld_n),
        .ram_we_o   (we),
        .ram_char_o (ch),
        .ram_row_o  (rw),
        .ram_cols_o (cols),
        .ram_clr_o  (clr),
        .bright_o   (lvl),
        .full_pk_o  (pk),
        .div16_o    (dv),
        .pwr_dn_o   (pd)
    );

    typedef struct packed {
        logic [7:0] b;
        logic       wr;
        logic [2:0] ch;
        logic [2:0] rw;
        logic [4:0] cols;
        logic       clr;
        logic [2:0] lvl;
        logic       pk;
        logic       dv;
        logic       pd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{8'hEB, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0}, // R6
        '{8'hA2, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0}, // R2
        '{8'h1E, 1'b1, 3'd2, 3'd0, 5'h1E, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0}, // R3
        '{8'h11, 1'b1, 3'd2, 3'd1, 5'h11, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0},
        '{8'h05, 1'b1, 3'd2, 3'd2, 5'h05, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0},
        '{8'hA5, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0}, // R5
        '{8'h0A, 1'b1, 3'd5, 3'd0, 5'h0A, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0}, // R5
        '{8'hF4, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0}, // R6
        '{8'h47, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0}, // R10
        '{8'h1F, 1'b1, 3'd5, 3'd1, 5'h1F, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0}, // R10
        '{8'hE7, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1}, // R7
        '{8'h03, 1'b1, 3'd5, 3'd2, 5'h03, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1}, // R7
        '{8'hE9, 1'b0, 3'd0, 3'd0, 5'h00, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0}, // R7
        '{8'hC0, 1'b0, 3'd0, 3'd0, 5'h00, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0}, // R8
        '{8'h15, 1'b1, 3'd0, 3'd0, 5'h15, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0}  // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frames nbits of v (LSB first); returns 2 ns after the third rising
    // edge following the load release, where the decoded result is due (R1).
    task automatic send_bits(input logic [7:0] v, input int nbits);
        @(negedge clk);
        sld_n = 1'b0;
        wait_neg(3);
        for (int i = 0; i < nbits; i++) begin
            sdat = v[i];
            wait_neg(3);
            sck = 1'b1;
            wait_neg(3);
            sck = 1'b0;
            wait_neg(3);
        end
        sld_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic expect_write(input string tag, input logic [2:0] ech,
                                input logic [2:0] erw, input logic [4:0] ecols);
        chk({tag, " we"}, 32'(we), 32'd1);
        chk({tag, " char"}, 32'(ch), 32'(ech));
        chk({tag, " row"}, 32'(rw), 32'(erw));
        chk({tag, " cols"}, 32'(cols), 32'(ecols));
    endtask

    task automatic expect_strobes_drop(input string tag);
        @(posedge clk);
        #2;
        chk({tag, " we drops"}, 32'(we), 32'd0);
        chk({tag, " clr drops"}, 32'(clr), 32'd0);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        // R9: values held during reset
        repeat (3) @(posedge clk);
        #2;
        chk("R9 reset we", 32'(we), 32'd0);
        chk("R9 reset clr", 32'(clr), 32'd0);
        chk("R9 reset level", 32'(lvl), 32'd0);
        chk("R9 reset peak", 32'(pk), 32'd1);
        chk("R9 reset div16", 32'(dv), 32'd0);
        chk("R9 reset pwr_dn", 32'(pd), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #2;
        chk("R9 no spurious write after reset", 32'(we), 32'd0);

        // Table walk: R1 R2 R3 R5 R6 R7 R8 R10
        for (int k = 0; k < NV; k++) begin
            send_bits(TBL[k].b, 8);
            chk($sformatf("R3/R10 vec%0d we", k), 32'(we), 32'(TBL[k].wr));
            if (TBL[k].wr) begin
                expect_write($sformatf("R3 vec%0d", k), TBL[k].ch, TBL[k].rw, TBL[k].cols);
            end
            chk($sformatf("R8 vec%0d clr", k), 32'(clr), 32'(TBL[k].clr));
            chk($sformatf("R6 vec%0d level", k), 32'(lvl), 32'(TBL[k].lvl));
            chk($sformatf("R6 vec%0d peak", k), 32'(pk), 32'(TBL[k].pk));
            chk($sformatf("R6 vec%0d div16", k), 32'(dv), 32'(TBL[k].dv));
            chk($sformatf("R7 vec%0d pwr_dn", k), 32'(pd), 32'(TBL[k].pd));
            expect_strobes_drop($sformatf("R3 vec%0d", k));
        end

        // R4: fill character 7 and overrun the bottom row
        send_bits(8'hA7, 8);
        chk("R2 select no write", 32'(we), 32'd0);
        for (int r = 0; r < 8; r++) begin
            send_bits(8'(r + 1), 8);
            expect_write($sformatf("R4 row%0d", r), 3'd7, (r < 6) ? 3'(r) : 3'd6, 5'(r + 1));
            expect_strobes_drop("R4");
        end

        // R11: four-bit frame after 0xA1 leaves 0xAA (select character 2)
        send_bits(8'hA1, 8);
        send_bits(8'h0A, 4);
        chk("R11 short frame no write", 32'(we), 32'd0);
        send_bits(8'h01, 8);
        expect_write("R11 short frame selected char", 3'd2, 3'd0, 5'h01);

        // R12: serial clocks with load high must not disturb the register
        sdat = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sck = 1'b1;
            wait_neg(3);
            sck = 1'b0;
            wait_neg(3);
        end
        send_bits(8'h00, 0);
        expect_write("R12 register held", 3'd2, 3'd1, 5'h01);
        chk("R12 level untouched", 32'(lvl), 32'd1);

        // R9: mid-run reset restores defaults and character 0 row 0
        send_bits(8'hF2, 8);
        chk("R6 level before reset", 32'(lvl), 32'd2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R9 mid reset level", 32'(lvl), 32'd0);
        chk("R9 mid reset peak", 32'(pk), 32'd1);
        chk("R9 mid reset div16", 32'(dv), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_neg(4);
        send_bits(8'h0C, 8);
        expect_write("R9 address back to 0", 3'd0, 3'd0, 5'h0C);

        summary();
        $finish;
    end

endmodule